// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches the synchronized input levels of a small GPIO port and turns per-pin conditions into a single interrupt request for the whole port. Each pin is configured on its own. It can be sensed by level or by edge. An edge-sensed pin can react to one transition direction or to both. A polarity bit picks high level or rising edge when set, and low level or falling edge when clear. A per-pin enable mask decides which detected conditions reach the shared request line.

Edge events latch into a raw status flag that software must acknowledge by writing a one to the matching bit of an acknowledge register. Level conditions are not latched: the raw flag simply tracks the input. Software reads the raw flags and the enabled (masked) flags through a small register bus. Read data is combinational and writes take effect at the clock edge. Edges are found by comparing each pin with its value at the previous clock edge.

Top module: `gpio_irq_unit`

## Requirements
- R1: Register offsets on `bus_addr`: 0 mode select (1 = level, 0 = edge), 1 dual-edge enable, 2 polarity, 3 enable mask. All four are read/write, one bit per pin. They change only on a write strobe (`bus_sel` and `bus_wr` high at a rising clock edge).
- R2: A pin with mode bit 1 has a raw flag equal to the pin when its polarity is 1 and to the inverted pin when its polarity is 0. The flag follows the pin in the same cycle and does not latch.
- R3: A pin with mode bit 0 and dual bit 0 sets its raw flag at the first clock edge where the pin differs from its value at the previous edge. A rising change sets it when polarity is 1, and a falling change sets it when polarity is 0.
- R4: A pin with mode bit 0 and dual bit 1 sets its raw flag on any change, whatever its polarity bit holds.
- R5: An edge-set raw flag stays set until a write to offset 6 (acknowledge) with a 1 in its bit. Writing 0 in a bit leaves that flag unchanged. Offset 6 always reads 0.
- R6: If a pin's qualifying edge and an acknowledge of the same bit fall in the same cycle, the flag ends up set.
- R7: Offset 4 reads the raw flags and offset 5 reads the raw flags ANDed with the enable mask. Writes to offsets 4 and 5 have no effect. Offset 7 reads 0.
- R8: `port_irq` is high exactly when at least one enabled raw flag is set.
- R9: Writing mode, dual or polarity bits never by itself sets an edge flag. While a pin is in level mode, its edge latch is held clear.
- R10: After reset, all configuration registers and raw flags are 0, `port_irq` is 0, and the previous-pin sample is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | PINS | Synchronized pin levels |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Combinational read data |
| port_irq | output | 1 | Combined port interrupt request |

## Verification
The assertions assume that `pin_in` is already synchronous to `clk`, so each pin is stable across a clock edge, and that bus strobes are held for one full cycle. The bench drives pins and strobes only at mid-cycle, one cycle per change, so both assumptions always hold. It sweeps every combination of mode, dual and polarity across all pins, using changing mask values and pin sequences. Acknowledge writes sometimes land in the same cycle as new edges.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DUAL  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_POL   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_EN    = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_MSKD  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 3'd6;

  // Edge qualification: any change when dual, else direction chosen by polarity.
  function automatic logic f_edge_hit(input logic dual, input logic pol,
                                      input logic cur, input logic prv);
    logic rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    if (dual) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Level qualification: active-high or active-low per polarity.
  function automatic logic f_level_hit(input logic pol, input logic cur);
    return pol ? cur : ~cur;
  endfunction
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic [PINS-1:0]   raw_vec,
  input  logic [PINS-1:0]   mskd_vec,
  output logic [PINS-1:0]   mode_vec,
  output logic [PINS-1:0]   dual_vec,
  output logic [PINS-1:0]   pol_vec,
  output logic [PINS-1:0]   en_vec,
  output logic [PINS-1:0]   ack_vec,
  output logic [PINS-1:0]   bus_rdata
);
  logic wr_stb;
  assign wr_stb = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_vec <= '0;
      dual_vec <= '0;
      pol_vec  <= '0;
      en_vec   <= '0;
    end else if (wr_stb) begin
      case (bus_addr)
        OFS_MODE: mode_vec <= bus_wdata;
        OFS_DUAL: dual_vec <= bus_wdata;
        OFS_POL:  pol_vec  <= bus_wdata;
        OFS_EN:   en_vec   <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign ack_vec = (wr_stb && bus_addr == OFS_ACK) ? bus_wdata : '0;

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = mode_vec;
      OFS_DUAL: bus_rdata = dual_vec;
      OFS_POL:  bus_rdata = pol_vec;
      OFS_EN:   bus_rdata = en_vec;
      OFS_RAW:  bus_rdata = raw_vec;
      OFS_MSKD: bus_rdata = mskd_vec;
      default:  bus_rdata = '0;
    endcase
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(mode_vec) && $stable(dual_vec) && $stable(pol_vec) && $stable(en_vec))); // R1
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_cur,
  input  logic cfg_mode,
  input  logic cfg_dual,
  input  logic cfg_pol,
  input  logic ack,
  output logic raw_flag
);
  logic pin_prev;
  logic edge_hit;
  logic level_hit;
  logic edge_flag;

  assign edge_hit  = f_edge_hit(cfg_dual, cfg_pol, pin_cur, pin_prev);
  assign level_hit = f_level_hit(cfg_pol, pin_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev  <= 1'b0;
      edge_flag <= 1'b0;
    end else begin
      pin_prev <= pin_cur;
      if (cfg_mode) edge_flag <= 1'b0;
      else          edge_flag <= edge_hit | (edge_flag & ~ack);
    end
  end

  assign raw_flag = cfg_mode ? level_hit : edge_flag;

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && !ack && !cfg_mode) |=> edge_flag); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && ack && !cfg_mode) |=> edge_flag); // R6
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_flag && !edge_hit) |=> !edge_flag); // R9
  AST_LEVEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> !edge_flag); // R9
  AST_DUAL_ANY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && cfg_dual && (pin_cur != pin_prev)) |=> edge_flag); // R4
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  output logic              port_irq
);
  logic [PINS-1:0] mode_vec, dual_vec, pol_vec, en_vec, ack_vec;
  logic [PINS-1:0] raw_vec, mskd_vec;

  gpio_irq_cfg #(.PINS(PINS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .raw_vec   (raw_vec),
    .mskd_vec  (mskd_vec),
    .mode_vec  (mode_vec),
    .dual_vec  (dual_vec),
    .pol_vec   (pol_vec),
    .en_vec    (en_vec),
    .ack_vec   (ack_vec),
    .bus_rdata (bus_rdata)
  );

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_cur  (pin_in[g]),
      .cfg_mode (mode_vec[g]),
      .cfg_dual (dual_vec[g]),
      .cfg_pol  (pol_vec[g]),
      .ack      (ack_vec[g]),
      .raw_flag (raw_vec[g])
    );
  end

  assign mskd_vec = raw_vec & en_vec;
  assign port_irq = |mskd_vec;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    port_irq |-> (en_vec != '0)); // R8
endmodule

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic port_irq;

  always #4 clk = ~clk;

  gpio_irq_unit #(.PINS(N)) i_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_irq(port_irq)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [N-1:0] m_mode = '0, m_dual = '0, m_pol = '0, m_en = '0, m_flag = '0, m_prev = '0, m_pin = '0;

  function automatic logic [N-1:0] exp_raw();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = m_mode[i] ? (m_pol[i] ? m_pin[i] : !m_pin[i]) : m_flag[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // One clock: drive pins and optional write, advance the reference model, wait for the edge.
  task automatic tick(input logic [N-1:0] pv, input bit wr, input logic [2:0] a, input logic [N-1:0] d);
    pin_in = pv; bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
    for (int i = 0; i < N; i++) begin
      logic hit, clr;
      if (m_dual[i]) hit = (pv[i] != m_prev[i]);
      else if (m_pol[i]) hit = pv[i] && !m_prev[i];
      else hit = !pv[i] && m_prev[i];
      clr = wr && (a == 3'd6) && d[i];
      if (m_mode[i]) m_flag[i] = 1'b0;
      else m_flag[i] = hit || (m_flag[i] && !clr);
    end
    m_prev = pv;
    m_pin = pv;
    if (wr) begin
      case (a)
        3'd0: m_mode = d;
        3'd1: m_dual = d;
        3'd2: m_pol  = d;
        3'd3: m_en   = d;
        default: ;
      endcase
    end
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic check_status(input string req);
    logic [N-1:0] v, e;
    e = exp_raw();
    rd(3'd4, v); check(req, v, e, "raw");
    rd(3'd5, v); check(req, v, e & m_en, "masked");
    check({req, ",R8"}, {7'd0, port_irq}, {7'd0, |(e & m_en)}, "port_irq");
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] pv;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v); check("R10", v, '0, "reset read");
    end
    check("R10", {7'd0, port_irq}, '0, "reset irq");

    // R1 readback of configuration
    tick('0, 1, 3'd0, 8'h5A); tick('0, 1, 3'd1, 8'hC3);
    tick('0, 1, 3'd2, 8'h96); tick('0, 1, 3'd3, 8'h0F);
    rd(3'd0, v); check("R1", v, 8'h5A, "mode readback");
    rd(3'd1, v); check("R1", v, 8'hC3, "dual readback");
    rd(3'd2, v); check("R1", v, 8'h96, "pol readback");
    rd(3'd3, v); check("R1", v, 8'h0F, "en readback");
    tick('0, 0, 3'd0, 8'hFF);
    rd(3'd0, v); check("R1", v, 8'h5A, "mode holds without strobe");

    // R3 rising edge, R5 sticky, R6 set wins
    tick('0, 1, 3'd0, 8'h00); tick('0, 1, 3'd1, 8'h00);
    tick('0, 1, 3'd2, 8'hFF); tick('0, 1, 3'd3, 8'hFF);
    tick('0, 1, 3'd6, 8'hFF);
    check_status("R3");
    tick(8'h01, 0, 3'd0, '0); check_status("R3");
    rd(3'd4, v); check("R3", v, 8'h01, "rising latched");
    tick(8'h00, 0, 3'd0, '0); check_status("R5");
    tick(8'h00, 1, 3'd6, 8'h00); check_status("R5");
    rd(3'd4, v); check("R5", v, 8'h01, "zero ack keeps flag");
    rd(3'd6, v); check("R5", v, 8'h00, "ack reads zero");
    tick(8'h00, 1, 3'd6, 8'h01); check_status("R5");
    rd(3'd4, v); check("R5", v, 8'h00, "ack clears");
    tick(8'h01, 1, 3'd6, 8'h01); check_status("R6");
    rd(3'd4, v); check("R6", v, 8'h01, "set wins over ack");
    // R7 writes to status offsets ignored
    tick(8'h01, 1, 3'd4, 8'hFE); check_status("R7");
    tick(8'h01, 1, 3'd5, 8'hFE); check_status("R7");
    rd(3'd7, v); check("R7", v, 8'h00, "unused offset");
    // R9 configuration changes never set edges; level mode clears latch
    tick(8'h01, 1, 3'd2, 8'h00); check_status("R9");
    tick(8'h01, 1, 3'd1, 8'hFF); check_status("R9");
    tick(8'h01, 1, 3'd0, 8'hFF); check_status("R9");
    tick(8'h01, 1, 3'd0, 8'h00); check_status("R9");
    rd(3'd4, v); check("R9", v, 8'h00, "latch cleared by level mode");

    // Sweep: each pin gets a rotating mode/dual/pol combination
    for (int k = 0; k < 8; k++) begin
      logic [N-1:0] cm, cd, cp;
      for (int i = 0; i < N; i++) begin
        int c;
        c = (i + k) % 8;
        cm[i] = c[2]; cd[i] = c[1]; cp[i] = c[0];
      end
      tick(m_pin, 1, 3'd0, cm); check_status("R9");
      tick(m_pin, 1, 3'd1, cd); check_status("R9");
      tick(m_pin, 1, 3'd2, cp); check_status("R9");
      tick(m_pin, 1, 3'd3, (k % 2 == 0) ? 8'hFF : 8'(8'hA5 ^ (k * 17))); check_status("R7");
      tick(m_pin, 1, 3'd6, 8'hFF); check_status("R5");
      for (int s = 0; s < 48; s++) begin
        if (s % 7 == 6) pv = ~m_pin;
        else pv = 8'((s * 73 + k * 29 + s * s) & 8'hFF);
        if (s % 5 == 4) tick(pv, 1, 3'd6, 8'(pv ^ 8'h3C));
        else tick(pv, 0, 3'd0, '0);
        check_status("R2,R3,R4,R5,R6");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule